// File: doc/BRIEF.md
# Fixed-point reciprocal approximator

This block returns an approximation of 1/x for a signed two's-complement fixed-point word x. It needs no divider. The magnitude of the input goes through a leading-zero counter, and the count shifts the magnitude into the interval [0.5, 1). A straight-line seed then estimates half the reciprocal of that normalised value. One Newton-Raphson step refines the estimate, using truncating multiplies throughout. A variable right shift then restores the scale of the requested output format. The sign of the input is applied at the end.

Any result that does not fit the output format is replaced by the largest positive code. A zero input gets the same code. The input and output formats are set separately by parameters, so an input with few integer bits can feed an output with many. The result is registered once, and a new input can be given on every clock.

Top module: `recip_approx`

## Requirements
- R1: The input format is signed Q(IN_INT).(IN_FRAC) and the output format is signed Q(OUT_INT).(OUT_FRAC), both two's complement. The defaults are Q12.12 in and Q12.12 out, 24 bits each. A Q6.10 input with a Q10.6 output is a supported configuration that meets R4 to R7.
- R2: The output register loads on every rising edge. The result for an input held before an edge appears after that edge and not before it. An input held constant gives a constant output.
- R3: A synchronous active-low reset sets the output to 0.
- R4: A zero input yields the largest positive code 2^(OW-1)-1, which is 0x7FFFFF for the default format.
- R5: Let E = floor(2^(IN_FRAC+OUT_FRAC)/|x|) in output LSBs. The output is the largest positive code whenever E ≥ MAX + MAX/64, for both signs of the input. It takes that code only when E ≥ MAX.
- R6: For a non-saturated result, the magnitude of the output lies between E − E/128 − 4 and E + 2.
- R7: A negative input yields the two's-complement negation of the result for its magnitude. An unsaturated result for a negative input is never positive.
- R8: Every position of the most significant set bit of the magnitude meets R6. This covers every power of two, its negation, and the most negative code. The internal leading-zero count equals the number of zeros above the top set bit.
- R9: The seed is 1.466 − 1.001·m, with constants taken at 12 fractional bits (raw 6004 and 4100) and scaled to the working precision. In the default format this gives 0x000FFB for an input of 1.0 and 0xFFF005 for −1.0. In the Q6.10 to Q10.6 format, 1.0 gives 0x003F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_val | input | IN_INT+IN_FRAC | Signed fixed-point operand |
| out_val | output | OUT_INT+OUT_FRAC | Registered signed fixed-point reciprocal |

## Verification
The only stored state is the output register, so any internal fault shows on the port one clock after the input that exposes it. A wrong leading-zero count moves the result by a power of two, which is far outside the R6 band. Such a fault shows on the first input whose top set bit lies at the affected position. An error in the seed or in the Newton arithmetic shows as a relative error that grows across the mantissa range, and it shifts the exact codes for ±1.0. A fault in the saturation or sign path shows as a wrong code near the overflow boundary, at zero, or for negative inputs.

// File: rtl/recip_pkg.sv
// recip_pkg: shared constants and helpers for the reciprocal approximator.
// Assumes constants are given in thousandths and converted by truncation.
package recip_pkg;

    // Seed line y0 = BIAS - SLOPE * m, with values in thousandths.
    localparam int unsigned SEED_BIAS_MILLI  = 1466;
    localparam int unsigned SEED_SLOPE_MILLI = 1001;

    // Convert a value in thousandths to an unsigned fixed-point raw code.
    function automatic logic [63:0] milli_to_fixed(input int unsigned milli,
                                                   input int unsigned frac);
        logic [63:0] wide;
        wide = 64'(milli) << frac;
        return wide / 64'd1000;
    endfunction

endpackage

// File: rtl/recip_lzc.sv
// recip_lzc: leading-zero counter built as a halving tree.
// Each count bit comes from one OR reduction over half of the current window,
// so the depth grows with log2(WIDTH). Assumes a non-zero input; for a zero
// input the count has no meaning and the caller must handle that case.
module recip_lzc #(
    parameter int WIDTH = 24,
    parameter int CW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    cnt
);

    localparam int PW  = 1 << CW;
    localparam int PAD = PW - WIDTH;

    logic [PW-1:0] padded;

    // Fill the unused low bits with ones so that padding never adds zeros.
    generate
        if (PAD > 0) begin : g_pad
            assign padded = {vec, {PAD{1'b1}}};
        end else begin : g_nopad
            assign padded = vec;
        end
    endgenerate

    logic [PW-1:0] win [0:CW-1];
    assign win[0] = padded;

    // Stage k: check whether the top half of the window is empty, then slide.
    generate
        for (genvar k = 0; k < CW; k++) begin : g_stage
            localparam int HALF = PW >> (k + 1);
            assign cnt[CW-1-k] = ~|win[k][PW-1 -: HALF];
            if (k < CW - 1) begin : g_next
                assign win[k+1] = cnt[CW-1-k] ? (win[k] << HALF) : win[k];
            end
        end
    endgenerate

endmodule

// File: rtl/recip_normalize.sv
// recip_normalize: shifts an unsigned magnitude left until its top bit is set.
// The result, read as a pure fraction, lies in [0.5, 1) when the magnitude
// is non-zero. The shift count is also returned for the denormalising step.
module recip_normalize #(
    parameter int IW = 24,
    parameter int CW = $clog2(IW)
) (
    input  logic [IW-1:0] mag,
    output logic [CW-1:0] lz,
    output logic [IW-1:0] m_norm
);

    recip_lzc #(.WIDTH(IW), .CW(CW)) u_lzc (
        .vec (mag),
        .cnt (lz)
    );

    // Barrel shift that places the most significant one at the top bit.
    always_comb begin
        m_norm = mag << lz;
    end

endmodule

// File: rtl/recip_newton.sv
// recip_newton: estimates r = 1/(2m) for a mantissa m in [0.5, 1).
// It uses a linear seed and one Newton-Raphson step, r1 = r0*(2 - 2m*r0).
// All values are unsigned, with G fractional bits and two guard bits above
// the binary point. Every multiply truncates.
module recip_newton #(
    parameter int G         = 24,
    parameter int SEED_FRAC = 12
) (
    input  logic [G-1:0] m,
    output logic [G+1:0] r1
);

    localparam int XW = G + 2;

    localparam logic [XW-1:0] K_BIAS  = XW'(recip_pkg::milli_to_fixed(
        recip_pkg::SEED_BIAS_MILLI, SEED_FRAC) << (G - SEED_FRAC));
    localparam logic [XW-1:0] K_SLOPE = XW'(recip_pkg::milli_to_fixed(
        recip_pkg::SEED_SLOPE_MILLI, SEED_FRAC) << (G - SEED_FRAC));
    localparam logic [XW-1:0] TWO     = XW'(1) << (G + 1);

    // Truncating fixed-point product of two XW-bit values with G fraction bits.
    function automatic logic [XW-1:0] mulq(input logic [XW-1:0] a,
                                           input logic [XW-1:0] b);
        logic [2*XW-1:0] p;
        p = {{XW{1'b0}}, a} * {{XW{1'b0}}, b};
        return XW'(p >> G);
    endfunction

    logic [XW-1:0] m_e;
    logic [XW-1:0] slope_m;
    logic [XW-1:0] r0;
    logic [XW-1:0] dr;
    logic [XW-1:0] corr;

    // Seed, error term and correction, evaluated in one combinational pass.
    always_comb begin
        m_e     = {2'b00, m};
        slope_m = mulq(K_SLOPE, m_e);
        r0      = K_BIAS - slope_m;
        dr      = mulq(m_e, r0);
        corr    = TWO - (dr << 1);
        r1      = mulq(r0, corr);
    end

endmodule

// File: rtl/recip_scale.sv
// recip_scale: moves the refined estimate back to the output scale, applies
// the sign and saturates. It assumes r1 has G = IW fractional bits and
// represents 1/(2m). The shift depends only on the leading-zero count.
module recip_scale #(
    parameter int IW       = 24,
    parameter int IN_FRAC  = 12,
    parameter int OW       = 24,
    parameter int OUT_FRAC = 12,
    parameter int CW       = $clog2(IW)
) (
    input  logic [IW+1:0] r1,
    input  logic [CW-1:0] lz,
    input  logic          neg,
    input  logic          zero,
    output logic [OW-1:0] res
);

    localparam int VW    = 2 * IW + 1;
    localparam int TBASE = 3 * IW - 2 - IN_FRAC - OUT_FRAC;
    localparam int SHW   = $clog2(TBASE + 1) + 1;
    localparam logic [OW-1:0] MAXC = {1'b0, {(OW-1){1'b1}}};

    logic [VW-1:0]  v;
    logic [SHW-1:0] shamt;
    logic [VW-1:0]  shifted;
    logic           over;
    logic [OW-1:0]  q;

    // Align to the output LSB: a right shift that shrinks as the count grows.
    always_comb begin
        v       = {r1, {(IW-1){1'b0}}};
        shamt   = SHW'(TBASE) - {{(SHW-CW){1'b0}}, lz};
        shifted = v >> shamt;
    end

    // Detect overflow of the magnitude and form the signed result.
    always_comb begin
        over = |shifted[VW-1:OW-1];
        q    = {1'b0, shifted[OW-2:0]};
        if (zero || over) begin
            res = MAXC;
        end else if (neg) begin
            res = -q;
        end else begin
            res = q;
        end
    end

endmodule

// File: rtl/recip_approx.sv
// recip_approx: top level of the fixed-point reciprocal approximator.
// It takes the magnitude, normalises it, refines the seed and rescales,
// then registers the result once. A new operand may be given every cycle.
// Assumes IN_FRAC+OUT_FRAC <= 2*IW-1, OW <= 2*IW and SEED_FRAC <= IW.
module recip_approx #(
    parameter int IN_INT    = 12,
    parameter int IN_FRAC   = 12,
    parameter int OUT_INT   = 12,
    parameter int OUT_FRAC  = 12,
    parameter int SEED_FRAC = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IN_INT+IN_FRAC-1:0]   in_val,
    output logic [OUT_INT+OUT_FRAC-1:0] out_val
);

    localparam int IW = IN_INT + IN_FRAC;
    localparam int OW = OUT_INT + OUT_FRAC;
    localparam int CW = $clog2(IW);

    logic          neg;
    logic          zero;
    logic [IW-1:0] mag;
    logic [CW-1:0] lz;
    logic [IW-1:0] m_norm;
    logic [IW+1:0] r1;
    logic [OW-1:0] res;

    // Split the operand into its sign and unsigned magnitude.
    always_comb begin
        neg  = in_val[IW-1];
        zero = (in_val == '0);
        mag  = neg ? (~in_val + IW'(1)) : in_val;
    end

    recip_normalize #(.IW(IW), .CW(CW)) u_norm (
        .mag    (mag),
        .lz     (lz),
        .m_norm (m_norm)
    );

    recip_newton #(.G(IW), .SEED_FRAC(SEED_FRAC)) u_newton (
        .m  (m_norm),
        .r1 (r1)
    );

    recip_scale #(
        .IW       (IW),
        .IN_FRAC  (IN_FRAC),
        .OW       (OW),
        .OUT_FRAC (OUT_FRAC),
        .CW       (CW)
    ) u_scale (
        .r1   (r1),
        .lz   (lz),
        .neg  (neg),
        .zero (zero),
        .res  (res)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_val <= '0;
        end else begin
            out_val <= res;
        end
    end

endmodule

// File: rtl/recip_approx_chk.sv
// recip_approx_chk: timing and structural properties of recip_approx.
// It is attached to every instance by the bind statement at the end.
module recip_approx_chk #(
    parameter int IN_INT   = 12,
    parameter int IN_FRAC  = 12,
    parameter int OUT_INT  = 12,
    parameter int OUT_FRAC = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [IN_INT+IN_FRAC-1:0]   in_val,
    input logic [OUT_INT+OUT_FRAC-1:0] out_val,
    input logic [IN_INT+IN_FRAC-1:0]   mag,
    input logic [$clog2(IN_INT+IN_FRAC)-1:0] lz,
    input logic [IN_INT+IN_FRAC-1:0]   m_norm
);

    localparam int IW = IN_INT + IN_FRAC;
    localparam int OW = OUT_INT + OUT_FRAC;
    localparam logic [OW-1:0] MAXC = {1'b0, {(OW-1){1'b1}}};

    // R3: reset clears the output register.
    a_r3_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (out_val == '0));

    // R4: zero operand gives the largest positive code one cycle later.
    a_r4_zero_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (in_val == '0) |=> (out_val == MAXC));

    // R7: a non-negative operand never yields a negative result.
    a_r7_sign_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !in_val[IW-1] |=> !out_val[OW-1]);

    // R7: a negative operand yields a negative, zero or saturated result.
    a_r7_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
        in_val[IW-1] |=> (out_val[OW-1] || (out_val == '0) || (out_val == MAXC)));

    // R2: an operand held across two edges leaves the output unchanged.
    a_r2_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (in_val == $past(in_val))) |=> (out_val == $past(out_val)));

    // R8: the count points exactly at the top set bit of the magnitude.
    a_r8_count_hits_top: assert property (@(posedge clk) disable iff (!rst_n)
        (mag != '0) |-> (mag[IW-1-int'(lz)] && ((mag >> (IW - int'(lz))) == '0)));

    // R8: after normalisation the mantissa has its top bit set.
    a_r8_mantissa_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (mag != '0) |-> m_norm[IW-1]);

endmodule

bind recip_approx recip_approx_chk #(
    .IN_INT   (IN_INT),
    .IN_FRAC  (IN_FRAC),
    .OUT_INT  (OUT_INT),
    .OUT_FRAC (OUT_FRAC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_val  (in_val),
    .out_val (out_val),
    .mag     (mag),
    .lz      (lz),
    .m_norm  (m_norm)
);

// File: tb/recip_approx_test.sv
// Bench for recip_approx: an exhaustive sweep of the Q6.10 to Q10.6
// configuration, a dense sweep of the default format, and directed cases.
module recip_approx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] a_in = '0;
    logic [23:0] a_out;
    logic [15:0] b_in = '0;
    logic [15:0] b_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    recip_approx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_val  (a_in),
        .out_val (a_out)
    );

    recip_approx #(.IN_INT(6), .IN_FRAC(10), .OUT_INT(10), .OUT_FRAC(6)) u_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_val  (b_in),
        .out_val (b_out)
    );

    // Compare one observed value with an exact expectation.
    task automatic expect_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Judge one result against the accuracy, saturation and sign rules.
    task automatic judge(input longint xs, input longint got, input int sumfrac,
                         input int ow, input string ctx);
        longint mag, maxc, ex, lo, hi, gm;
        bit ok;
        string req;
        checks++;
        mag  = (xs < 0) ? -xs : xs;
        maxc = (longint'(1) << (ow - 1)) - 1;
        ok   = 1'b1;
        req  = "R6";
        if (mag == 0) begin
            req = "R4";
            ex  = maxc;
            ok  = (got == maxc);
        end else begin
            ex = (longint'(1) << sumfrac) / mag;
            if (got == maxc) begin
                req = "R5";
                ok  = (ex >= maxc);
            end else if (ex >= maxc + maxc / 64) begin
                req = "R5";
                ok  = 1'b0;
            end else begin
                gm = (xs < 0) ? -got : got;
                if (xs < 0 && got > 0) begin
                    req = "R7";
                    ok  = 1'b0;
                end else begin
                    lo = ex - ex / 128 - 4;
                    hi = ex + 2;
                    ok = (gm >= lo) && (gm <= hi);
                end
            end
        end
        if (!ok) begin
            fails++;
            $display("FAIL %s %s x=%0d actual=%0d expected=%0d (magnitude)",
                     req, ctx, xs, got, ex);
        end
    endtask

    logic [23:0] prev_a;
    logic [15:0] prev_b;
    bit          have_prev = 1'b0;
    string       ctx_a = "";
    string       ctx_b = "";

    // Pipelined step: judge the previous operands, then apply new ones.
    task automatic step(input logic [23:0] xa, input logic [15:0] xb);
        @(negedge clk);
        if (have_prev) begin
            judge(longint'($signed(prev_a)), longint'($signed(a_out)), 24, 24, ctx_a);
            judge(longint'($signed(prev_b)), longint'($signed(b_out)), 16, 16, ctx_b);
        end
        a_in = xa;
        b_in = xb;
        prev_a = xa;
        prev_b = xb;
        have_prev = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_prev) begin
            judge(longint'($signed(prev_a)), longint'($signed(a_out)), 24, 24, ctx_a);
            judge(longint'($signed(prev_b)), longint'($signed(b_out)), 16, 16, ctx_b);
        end
        have_prev = 1'b0;
    endtask

    // Two-cycle probe of the default instance.
    task automatic probe(input logic [23:0] x, output logic [23:0] y);
        @(negedge clk);
        a_in = x;
        @(negedge clk);
        y = a_out;
    endtask

    initial begin
        logic [23:0] yp, yn;
        repeat (3) @(negedge clk);
        // R3: outputs cleared while reset is held, even with a zero operand.
        expect_eq("R3 reset default", longint'(a_out), 0);
        expect_eq("R3 reset alt", longint'(b_out), 0);
        rst_n = 1'b1;

        // R4 and R2: zero operand, then 1.0 arrives exactly one edge later.
        @(negedge clk);
        @(negedge clk);
        expect_eq("R4 zero default", longint'(a_out), 24'h7FFFFF);
        expect_eq("R4 zero alt", longint'(b_out), 16'h7FFF);
        a_in = 24'h001000;
        b_in = 16'h0400;
        #1;
        expect_eq("R2 no change before edge", longint'(a_out), 24'h7FFFFF);
        @(negedge clk);
        expect_eq("R2 R9 one-cycle result for 1.0", longint'(a_out), 24'h000FFB);
        expect_eq("R1 R9 alt result for 1.0", longint'(b_out), 16'h003F);
        repeat (3) @(negedge clk);
        expect_eq("R2 held operand keeps result", longint'(a_out), 24'h000FFB);
        probe(24'hFFF000, yn);
        expect_eq("R9 result for -1.0", longint'(yn), 24'hFFF005);

        // R3: synchronous reset in the middle of operation.
        @(negedge clk);
        a_in = 24'h002000;
        rst_n = 1'b0;
        @(negedge clk);
        expect_eq("R3 mid-run reset", longint'(a_out), 0);
        rst_n = 1'b1;

        // R1 R6: exhaustive alt sweep with spread default operands.
        ctx_a = "R6 spread default";
        ctx_b = "R1 alt exhaustive";
        for (int i = 0; i < 65536; i++) begin
            step({16'(i), 8'(i)}, 16'(i));
        end
        // R5 R6: every small default operand, which spans the overflow boundary.
        ctx_a = "R5 small default";
        ctx_b = "R7 alt negated";
        for (int i = 0; i < 4096; i++) begin
            step(24'(i), 16'(-i));
        end
        // R8: every top-bit position, both signs.
        ctx_a = "R8 power of two default";
        ctx_b = "R8 power of two alt";
        for (int k = 0; k < 24; k++) begin
            step(24'(1) << k, 16'(1) << (k % 16));
            step(-(24'(1) << k), -(16'(1) << (k % 16)));
        end
        step(24'h800000, 16'h8000);
        flush();

        // R7: negation symmetry on the default instance.
        for (int j = 0; j < 8; j++) begin
            logic [23:0] v;
            case (j)
                0: v = 24'h000001;
                1: v = 24'h000003;
                2: v = 24'h000800;
                3: v = 24'h001000;
                4: v = 24'h003039;
                5: v = 24'h123456;
                6: v = 24'h7FFFFF;
                default: v = 24'h0012D1;
            endcase
            probe(v, yp);
            probe(-v, yn);
            if (yp == 24'h7FFFFF) begin
                expect_eq("R7 both saturate", longint'(yn), 24'h7FFFFF);
            end else begin
                expect_eq("R7 negated result", longint'(yn), longint'(24'(-yp)));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule